// File: doc/BRIEF.md
# Line Error Counter Bank

This block keeps nine independent error tallies for an E1 line. Event detection elsewhere on the chip presents one single-cycle pulse per counter. The eight counters other than the frame-alignment one are 16 bits wide. The frame-alignment counter is only 8 bits wide, so it wraps once every 256 events. Software reaches every counter, snapshot, flag and mask through a flat word-addressed register port. It can load any counter with a preset value or with zero.

A one-cycle tick, supplied from an external one-second timer, copies four counters into read-only snapshot registers in the same cycle: CRC, E-bit, frame-alignment and bipolar-violation. A counter that wraps records the event in a clear-on-read overflow latch. Each counter also records every event in a pending flag that is cleared by writing 1 to it. Two mask registers select which of these two flag sets drive the single interrupt line. A control bit zeroes all counters and holds them at zero for as long as it stays set.

Top module: `ecb_bank`

With the default parameters the address map is:

- 0..8: counters. Index 0 is CRC, 1 is E-bit, 2 is frame-alignment, 3 is bipolar-violation, 4..8 are auxiliary.
- 9..12: snapshots of counters 0..3.
- 13: overflow latch.
- 14: event flags.
- 15: event mask.
- 16: overflow mask.
- 17: control, bit 0 = hold-clear.

## Requirements
- R1: A pulse on evt_i[i] adds one to counter i. The new value is readable from the clock edge that sampled the pulse.
- R2: A write to counter address i (0..8) loads the low bits of wdata_i that fit that counter. If an event on the same counter lands in the same cycle, the write wins.
- R3: An event on a counter holding its all-ones value wraps it to zero and sets bit i of the overflow latch (address 13). Counter 2 is 8 bits wide and wraps after 255; the other counters are 16 bits wide.
- R4: A read of address 13 returns the latch and then clears it. A bit whose overflow happens in the same cycle as that read stays set afterwards.
- R5: A sec_tick_i pulse copies counters 0..3, as they stood before that cycle's updates, into snapshot addresses 9..12. Snapshots change at no other time, and writes to them have no effect.
- R6: While bit 0 of control address 17 is 1, every counter reads zero and ignores both events and writes.
- R7: Bit i of the event flag register (address 14) is set by a pulse on evt_i[i], including while the hold-clear bit is set. Writing 1 to a bit clears it, but a new pulse in the same cycle keeps it set.
- R8: irq_o is 1 exactly when some bit is set both in the event flags and in the event mask (address 15), or both in the overflow latch and in the overflow mask (address 16). A mask bit of 1 enables its source.
- R9: A read with rd_en_i high puts the addressed value, zero-extended, on rdata_o at the next edge, and rdata_o holds it until the next read. Addresses above 17 read as zero.
- R10: After reset, every counter, snapshot, flag, mask, control bit, rdata_o and irq_o is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 9 | One-cycle error event pulses, one per counter |
| sec_tick_i | input | 1 | One-second snapshot tick |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 5 | Register word address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Registered read data |
| irq_o | output | 1 | Interrupt, OR of unmasked pending flags |

## Verification
The bench preloads counters one below their wrap point to reach both widths of wrap. A design that sized the frame-alignment counter like the others would miss the overflow after 256 events. The bench also lines up a latch read with a fresh overflow in the same cycle; a design that cleared before merging would lose that overflow. It puts a write-1-to-clear in the same cycle as a new event, and a write in the same cycle as an event, so a wrong priority shows up as a stale flag or a count that is off by one. Ticks are mixed with same-cycle increments, and the hold-clear bit is toggled while events and writes keep arriving. A snapshot that captured post-update values, or a hold that let writes through, would then diverge from the reference model on the next read.

// File: rtl/ecb_pkg.sv
package ecb_pkg;
   // Counter slot assignment; the first four are the snapshot sources in this order.
   localparam int IDX_CRC  = 0;
   localparam int IDX_EBIT = 1;
   localparam int IDX_FAS  = 2;
   localparam int IDX_BPV  = 3;

   // Width of counter slot idx: the frame-alignment slot is narrow, all others wide.
   function automatic int slot_width(input int idx, input int narrow_w, input int wide_w);
      return (idx == IDX_FAS) ? narrow_w : wide_w;
   endfunction
endpackage

// File: rtl/ecb_counter.sv
module ecb_counter #(
   parameter int W      = 16,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hold_i,
   input  logic              load_i,
   input  logic [DATA_W-1:0] ldata_i,
   input  logic              inc_i,
   output logic [DATA_W-1:0] val_o,
   output logic              wrap_o
);
   localparam logic [W-1:0] ALL_ONES = '1;

   if (W < 1 || W > DATA_W) begin : g_bad_w
      $error("ecb_counter: W must lie in 1..DATA_W");
   end

   logic [W-1:0] cnt_q;

   // Increment applies only when neither hold nor load takes the cycle.
   assign wrap_o = inc_i & ~hold_i & ~load_i & (cnt_q == ALL_ONES);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (hold_i) cnt_q <= '0;
      else if (load_i) cnt_q <= ldata_i[W-1:0];
      else if (inc_i)  cnt_q <= cnt_q + 1'b1;
   end

   if (W == DATA_W) begin : g_full
      assign val_o = cnt_q;
   end else begin : g_ext
      assign val_o = {{(DATA_W-W){1'b0}}, cnt_q};
   end
endmodule

// File: rtl/ecb_snapshot.sv
module ecb_snapshot #(
   parameter int NUM_SNAP = 4,
   parameter int DATA_W   = 16
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             tick_i,
   input  logic [NUM_SNAP-1:0][DATA_W-1:0]  src_i,
   output logic [NUM_SNAP-1:0][DATA_W-1:0]  snap_o
);
   for (genvar k = 0; k < NUM_SNAP; k++) begin : g_snap
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      snap_o[k] <= '0;
         else if (tick_i) snap_o[k] <= src_i[k];
      end
   end
endmodule

// File: rtl/ecb_flags.sv
module ecb_flags #(
   parameter int N = 9
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] evt_i,
   input  logic [N-1:0] wrap_i,
   input  logic [N-1:0] evf_clr_i,
   input  logic         ovf_rd_i,
   input  logic         emask_we_i,
   input  logic         omask_we_i,
   input  logic [N-1:0] mask_wdata_i,
   output logic [N-1:0] evf_q,
   output logic [N-1:0] ovf_q,
   output logic [N-1:0] emask_q,
   output logic [N-1:0] omask_q,
   output logic         irq_o
);
   logic [N-1:0] evf_d, ovf_d;

   // New sets are merged after the clear so a same-cycle set survives.
   assign evf_d = (evf_q & ~evf_clr_i) | evt_i;
   assign ovf_d = (ovf_q & ~{N{ovf_rd_i}}) | wrap_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         evf_q   <= '0;
         ovf_q   <= '0;
         emask_q <= '0;
         omask_q <= '0;
      end else begin
         evf_q <= evf_d;
         ovf_q <= ovf_d;
         if (emask_we_i) emask_q <= mask_wdata_i;
         if (omask_we_i) omask_q <= mask_wdata_i;
      end
   end

   assign irq_o = |((evf_q & emask_q) | (ovf_q & omask_q));
endmodule

// File: rtl/ecb_bank.sv
module ecb_bank
   import ecb_pkg::*;
#(
   parameter int NUM_CNT  = 9,
   parameter int NUM_SNAP = 4,
   parameter int CNT_W    = 16,
   parameter int FAS_W    = 8,
   parameter int DATA_W   = 16,
   parameter int ADDR_W   = 5
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_CNT-1:0]  evt_i,
   input  logic                sec_tick_i,
   input  logic                wr_en_i,
   input  logic                rd_en_i,
   input  logic [ADDR_W-1:0]   addr_i,
   input  logic [DATA_W-1:0]   wdata_i,
   output logic [DATA_W-1:0]   rdata_o,
   output logic                irq_o
);
   localparam int LAST_ADDR = NUM_CNT + NUM_SNAP + 4;
   localparam logic [ADDR_W-1:0] A_SNAP0 = ADDR_W'(NUM_CNT);
   localparam logic [ADDR_W-1:0] A_OVF   = ADDR_W'(NUM_CNT + NUM_SNAP);
   localparam logic [ADDR_W-1:0] A_EVF   = ADDR_W'(NUM_CNT + NUM_SNAP + 1);
   localparam logic [ADDR_W-1:0] A_EMSK  = ADDR_W'(NUM_CNT + NUM_SNAP + 2);
   localparam logic [ADDR_W-1:0] A_OMSK  = ADDR_W'(NUM_CNT + NUM_SNAP + 3);
   localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(LAST_ADDR);

   if (NUM_SNAP > NUM_CNT || NUM_SNAP < 1) begin : g_bad_snap
      $error("ecb_bank: NUM_SNAP must lie in 1..NUM_CNT");
   end
   if (DATA_W < NUM_CNT) begin : g_bad_dw
      $error("ecb_bank: DATA_W must hold one bit per counter");
   end
   if ((1 << ADDR_W) <= LAST_ADDR) begin : g_bad_aw
      $error("ecb_bank: ADDR_W too small for the register map");
   end
   if (CNT_W > DATA_W || FAS_W > DATA_W) begin : g_bad_cw
      $error("ecb_bank: counter widths must not exceed DATA_W");
   end

   logic [NUM_CNT-1:0][DATA_W-1:0]  cnt_val;
   logic [NUM_SNAP-1:0][DATA_W-1:0] snap_val;
   logic [NUM_CNT-1:0]              cnt_load, cnt_wrap;
   logic [NUM_CNT-1:0]              evf_q, ovf_q, emask_q, omask_q, evf_clr;
   logic                            hold_q;
   logic                            ovf_rd;
   logic [DATA_W-1:0]               rd_val;

   // Control register: bit 0 is the hold-clear bit.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              hold_q <= 1'b0;
      else if (wr_en_i && addr_i == A_CTRL)    hold_q <= wdata_i[0];
   end

   for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
      localparam int CW = slot_width(i, FAS_W, CNT_W);
      assign cnt_load[i] = wr_en_i && (addr_i == ADDR_W'(i));
      ecb_counter #(.W(CW), .DATA_W(DATA_W)) u_cnt (
         .clk     (clk),
         .rst_n   (rst_n),
         .hold_i  (hold_q),
         .load_i  (cnt_load[i]),
         .ldata_i (wdata_i),
         .inc_i   (evt_i[i]),
         .val_o   (cnt_val[i]),
         .wrap_o  (cnt_wrap[i])
      );
   end

   ecb_snapshot #(.NUM_SNAP(NUM_SNAP), .DATA_W(DATA_W)) u_snap (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_i (sec_tick_i),
      .src_i  (cnt_val[NUM_SNAP-1:0]),
      .snap_o (snap_val)
   );

   assign evf_clr = (wr_en_i && addr_i == A_EVF) ? wdata_i[NUM_CNT-1:0] : '0;
   assign ovf_rd  = rd_en_i && (addr_i == A_OVF);

   ecb_flags #(.N(NUM_CNT)) u_flags (
      .clk          (clk),
      .rst_n        (rst_n),
      .evt_i        (evt_i),
      .wrap_i       (cnt_wrap),
      .evf_clr_i    (evf_clr),
      .ovf_rd_i     (ovf_rd),
      .emask_we_i   (wr_en_i && addr_i == A_EMSK),
      .omask_we_i   (wr_en_i && addr_i == A_OMSK),
      .mask_wdata_i (wdata_i[NUM_CNT-1:0]),
      .evf_q        (evf_q),
      .ovf_q        (ovf_q),
      .emask_q      (emask_q),
      .omask_q      (omask_q),
      .irq_o        (irq_o)
   );

   // Read mux: counters, then snapshots, then the fixed registers.
   always_comb begin
      rd_val = '0;
      for (int i = 0; i < NUM_CNT; i++)
         if (addr_i == ADDR_W'(i)) rd_val = cnt_val[i];
      for (int k = 0; k < NUM_SNAP; k++)
         if (addr_i == A_SNAP0 + ADDR_W'(k)) rd_val = snap_val[k];
      if (addr_i == A_OVF)  rd_val = DATA_W'(ovf_q);
      if (addr_i == A_EVF)  rd_val = DATA_W'(evf_q);
      if (addr_i == A_EMSK) rd_val = DATA_W'(emask_q);
      if (addr_i == A_OMSK) rd_val = DATA_W'(omask_q);
      if (addr_i == A_CTRL) rd_val = DATA_W'(hold_q);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       rdata_o <= '0;
      else if (rd_en_i) rdata_o <= rd_val;
   end
endmodule

// File: rtl/ecb_bank_chk.sv
module ecb_bank_chk #(
   parameter int NUM_CNT  = 9,
   parameter int NUM_SNAP = 4,
   parameter int DATA_W   = 16,
   parameter int ADDR_W   = 5
) (
   input logic                             clk,
   input logic                             rst_n,
   input logic [NUM_CNT-1:0]               evt_i,
   input logic                             sec_tick_i,
   input logic                             wr_en_i,
   input logic                             rd_en_i,
   input logic [ADDR_W-1:0]                addr_i,
   input logic                             irq_o,
   input logic                             hold_q,
   input logic [NUM_CNT-1:0][DATA_W-1:0]   cnt_val,
   input logic [NUM_SNAP-1:0][DATA_W-1:0]  snap_val,
   input logic [NUM_CNT-1:0]               evf_q,
   input logic [NUM_CNT-1:0]               ovf_q,
   input logic [NUM_CNT-1:0]               emask_q
);
   localparam logic [ADDR_W-1:0] A_OVF  = ADDR_W'(NUM_CNT + NUM_SNAP);
   localparam logic [ADDR_W-1:0] A_EMSK = ADDR_W'(NUM_CNT + NUM_SNAP + 2);

   a_r6_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
      hold_q |=> (cnt_val == '0));

   a_r5_snap_still: assert property (@(posedge clk) disable iff (!rst_n)
      !sec_tick_i |=> $stable(snap_val));

   a_r7_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_i != '0) |=> ((evf_q & $past(evt_i)) == $past(evt_i)));

   a_r4_latch_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_en_i && addr_i == A_OVF) |=> ((ovf_q & $past(ovf_q)) == $past(ovf_q)));

   a_r8_irq_raise: assert property (@(posedge clk) disable iff (!rst_n)
      ((evt_i & emask_q) != '0) && !(wr_en_i && addr_i == A_EMSK) |=> irq_o);
endmodule

bind ecb_bank ecb_bank_chk #(
   .NUM_CNT(NUM_CNT), .NUM_SNAP(NUM_SNAP), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .sec_tick_i(sec_tick_i),
   .wr_en_i(wr_en_i), .rd_en_i(rd_en_i), .addr_i(addr_i), .irq_o(irq_o),
   .hold_q(hold_q), .cnt_val(cnt_val), .snap_val(snap_val),
   .evf_q(evf_q), .ovf_q(ovf_q), .emask_q(emask_q)
);

// File: tb/sim_ecb_bank.sv
module sim_ecb_bank;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [8:0]  evt = '0;
   logic        tick = 1'b0, wr = 1'b0, rd = 1'b0;
   logic [4:0]  addr = '0;
   logic [15:0] wdata = '0;
   logic [15:0] rdata;
   logic        irq;

   always #5 clk = ~clk;

   ecb_bank u0 (
      .clk(clk), .rst_n(rst_n), .evt_i(evt), .sec_tick_i(tick),
      .wr_en_i(wr), .rd_en_i(rd), .addr_i(addr), .wdata_i(wdata),
      .rdata_o(rdata), .irq_o(irq)
   );

   // Reference model state
   int          m_cnt [9];
   int          m_snap [4];
   int          m_evf, m_ovf, m_emsk, m_omsk, m_hold, m_rdata;
   int          compared = 0, mismatched = 0, cycles = 0;
   string       req = "R10";

   function automatic int cmax(int i);
      return (i == 2) ? 255 : 65535;
   endfunction

   function automatic int model_read(int a);
      if (a < 9)   return m_cnt[a];
      if (a < 13)  return m_snap[a-9];
      if (a == 13) return m_ovf;
      if (a == 14) return m_evf;
      if (a == 15) return m_emsk;
      if (a == 16) return m_omsk;
      if (a == 17) return m_hold;
      return 0;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         foreach (m_cnt[i]) m_cnt[i] = 0;
         foreach (m_snap[k]) m_snap[k] = 0;
         m_evf = 0; m_ovf = 0; m_emsk = 0; m_omsk = 0; m_hold = 0; m_rdata = 0;
      end else begin
         int a, w, nov, rv;
         int old [9];
         a = int'(addr); w = int'(wdata); nov = 0;
         rv = model_read(a);
         foreach (m_cnt[i]) old[i] = m_cnt[i];
         foreach (m_cnt[i]) begin
            if (m_hold != 0) m_cnt[i] = 0;
            else if (wr && a == i) m_cnt[i] = w & cmax(i);
            else if (evt[i]) begin
               if (old[i] == cmax(i)) begin m_cnt[i] = 0; nov |= (1 << i); end
               else m_cnt[i] = old[i] + 1;
            end
         end
         if (tick) foreach (m_snap[k]) m_snap[k] = old[k];
         m_evf = (m_evf & ~((wr && a == 14) ? (w & 511) : 0)) | int'(evt);
         m_ovf = ((rd && a == 13) ? 0 : m_ovf) | nov;
         if (wr && a == 15) m_emsk = w & 511;
         if (wr && a == 16) m_omsk = w & 511;
         if (wr && a == 17) m_hold = w & 1;
         if (rd) m_rdata = rv;
      end
   end

   // Compare on every falling edge once out of reset.
   always @(negedge clk) begin
      int exp_irq;
      cycles++;
      if (rst_n) begin
         exp_irq = (((m_evf & m_emsk) | (m_ovf & m_omsk)) != 0) ? 1 : 0;
         compared++;
         if (int'(rdata) != m_rdata || int'(irq) != exp_irq) begin
            mismatched++;
            $display("FAIL %s: rdata=%h irq=%0d expected rdata=%h irq=%0d",
                     req, rdata, irq, m_rdata[15:0], exp_irq);
         end
      end
      if (cycles > 200000) begin
         mismatched++;
         $display("FAIL watchdog: cycles=%0d expected below 200000", cycles);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   task automatic cyc(input logic w, input logic r, input int a, input int d,
                      input logic [8:0] e, input logic t);
      @(negedge clk);
      wr = w; rd = r; addr = 5'(a); wdata = 16'(d); evt = e; tick = t;
      @(posedge clk);
   endtask

   task automatic idle();
      cyc(0, 0, 0, 0, '0, 0);
   endtask

   task automatic wreg(input int a, input int d);
      cyc(1, 0, a, d, '0, 0);
   endtask

   task automatic rreg(input int a);
      cyc(0, 1, a, 0, '0, 0);
      idle();
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      // R10 and R9: every address reads zero after reset, beyond-map too
      req = "R10";
      for (int a = 0; a < 20; a++) rreg(a);
      req = "R9";
      rreg(25);
      // R1: single and multi-bit event patterns
      req = "R1";
      cyc(0, 0, 0, 0, 9'h001, 0);
      cyc(0, 0, 0, 0, 9'h1FF, 0);
      cyc(0, 0, 0, 0, 9'h0AA, 0);
      for (int a = 0; a < 9; a++) rreg(a);
      // R2: write beats event on the same counter
      req = "R2";
      cyc(1, 0, 3, 16'h1234, 9'h008, 0);
      rreg(3);
      cyc(1, 0, 2, 16'hABCD, 9'h000, 0);
      rreg(2);
      // R3: narrow wrap after 255, wide wrap after 65535
      req = "R3";
      wreg(2, 254);
      cyc(0, 0, 0, 0, 9'h004, 0);
      cyc(0, 0, 0, 0, 9'h004, 0);
      rreg(2);
      wreg(0, 16'hFFFF);
      cyc(0, 0, 0, 0, 9'h001, 0);
      rreg(0);
      // R4: read clears, same-cycle overflow survives
      req = "R4";
      rreg(13);
      rreg(13);
      wreg(6, 16'hFFFF);
      cyc(0, 1, 13, 0, 9'h040, 0);
      idle();
      rreg(13);
      rreg(13);
      // R5: snapshot takes pre-update values; write to snapshot ignored
      req = "R5";
      cyc(0, 0, 0, 0, 9'h00F, 1);
      for (int a = 9; a < 13; a++) rreg(a);
      wreg(10, 16'h5555);
      cyc(0, 0, 0, 0, 9'h00F, 0);
      for (int a = 9; a < 13; a++) rreg(a);
      // R6: hold-clear zeroes and blocks events and writes
      req = "R6";
      wreg(17, 1);
      cyc(1, 0, 4, 77, 9'h1FF, 0);
      cyc(0, 0, 0, 0, 9'h1FF, 0);
      for (int a = 0; a < 9; a++) rreg(a);
      rreg(17);
      wreg(17, 0);
      cyc(0, 0, 0, 0, 9'h010, 0);
      rreg(4);
      // R7: write-1-to-clear, set wins over clear
      req = "R7";
      rreg(14);
      cyc(1, 0, 14, 16'h01FF, 9'h020, 0);
      rreg(14);
      wreg(14, 16'h01FF);
      rreg(14);
      // R8: masks steer the interrupt
      req = "R8";
      wreg(15, 16'h0002);
      cyc(0, 0, 0, 0, 9'h001, 0);
      cyc(0, 0, 0, 0, 9'h002, 0);
      wreg(14, 16'h0003);
      wreg(16, 16'h0100);
      wreg(8, 16'hFFFF);
      cyc(0, 0, 0, 0, 9'h100, 0);
      idle();
      rreg(13);
      rreg(16);
      // Mixed traffic against the model
      req = "R9";
      for (int n = 0; n < 3000; n++) begin
         int a, d, op;
         a  = int'($urandom_range(0, 19));
         op = int'($urandom_range(0, 3));
         d  = int'($urandom_range(0, 65535));
         if (a == 17) d = ($urandom_range(0, 7) == 0) ? 1 : 0;
         if (a < 9 && $urandom_range(0, 3) == 0) d = cmax(a);
         cyc(op == 1, op == 2, a, d,
             9'($urandom) & 9'($urandom) & 9'($urandom),
             $urandom_range(0, 40) == 0);
      end
      wreg(17, 0);
      for (int a = 0; a < 18; a++) rreg(a);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule